// File: doc/BRIEF.md
# Out-of-Order Dataflow Issue Scheduler

This block sits after instruction decode in a floating-point pipeline. It takes at most one decoded operation per clock in program order. Each operation has a class (load, add or multiply), one destination register and up to two source registers. At issue the operation receives a rename tag. Here the tag is the index of the scheduler slot that holds it. A per-register scoreboard records whether each architectural register waits on an in-flight producer, and which tag that producer has.

An operation whose sources are all available starts executing in its issue cycle. Otherwise it waits in its slot and watches the completion broadcast until every missing source's producer tag appears. Execution units are never scarce, so any number of operations run at once. Each class has its own fixed, parameterised latency. When an operation's latency has elapsed, the bit for its tag pulses on the completion vector. That pulse wakes matching waiters in the same cycle and clears the destination's pending flag, provided no younger writer has since claimed that register. Loads carry no register sources, and the result data of loads is outside this block.

Each slot runs a three-state controller. FREE leaves on an allocate: to EXEC when no source is missing, or to WAIT otherwise. WAIT stays put until the last missing tag broadcasts, then moves to EXEC with its counter loaded. EXEC counts down and returns to FREE after the cycle in which it reports completion.

Top module: `df_sched`

## Requirements
- R1: When `in_valid` and `in_ready` are both high in a cycle, exactly one operation is accepted in that cycle. The tag given on `in_tag` is the lowest-numbered free slot.
- R2: A slot is occupied from the cycle after its issue through its completion cycle. `in_ready` is low exactly when all `NUM_ENT` slots are occupied, and the operation offered in such a cycle is not taken.
- R3: The operation class is encoded on `in_op` as 2'b00 = load, 2'b01 = add and 2'b10 = multiply. The latencies are the parameters `LAT_LOAD`, `LAT_ADD` and `LAT_MUL`, with defaults 2, 4 and 20. The result is ready in cycle start + latency.
- R4: The start cycle is the maximum of the issue cycle and the ready cycles of the enabled sources. A source whose producer completes in the issue cycle itself counts as ready.
- R5: A load ignores both source enables and always starts in its issue cycle.
- R6: Bit t of `done_vec` is high for exactly one cycle, in tag t's ready cycle. Several bits may be high in the same cycle.
- R7: `reg_pending[r]` is high from the cycle after the youngest writer of r issues through that writer's ready cycle.
- R8: A reader waits on the tag of the youngest writer issued before it. An older writer's completion neither wakes that reader nor clears the register's pending flag.
- R9: After reset `in_ready` is 1, `in_tag` is 0, `done_vec` is 0 and `reg_pending` is 0.
- R10: A completion changes the pending flag of its own destination register only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered this cycle |
| in_op | input | 2 | Operation class |
| in_dst | input | AW | Destination register |
| in_src_a | input | AW | First source register |
| in_src_a_en | input | 1 | First source is used |
| in_src_b | input | AW | Second source register |
| in_src_b_en | input | 1 | Second source is used |
| in_ready | output | 1 | A free slot exists |
| in_tag | output | TW | Tag that the offered operation receives |
| done_vec | output | NUM_ENT | Per-tag completion pulse |
| reg_pending | output | NUM_ARCH | Per-register waiting-on-producer flag |

## Verification
`in_ready` and `in_tag` are checked in the cycle the operation is offered. `reg_pending` is checked from the cycle after acceptance. A tag's `done_vec` pulse is due in exactly start + latency, where the start cycle comes from the acceptance cycle and the sources' ready cycles. Inputs change just after a rising edge and outputs are sampled at the falling edge. The bench numbers cycles from the rising edges and computes every expected output for that cycle number from a timing model of the issued operations. Directed sequences cover a dependent load/multiply/accumulate chain, a full-scheduler stall and register rewrites. Seeded random operations over a small register set cover the rest.

// File: rtl/df_sched_pkg.sv
package df_sched_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_MUL  = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SL_FREE = 2'b00,
        SL_WAIT = 2'b01,
        SL_EXEC = 2'b10
    } slot_st_e;

endpackage

// File: rtl/df_pick.sv
module df_pick #(
    parameter int N  = 16,
    localparam int TW = $clog2(N)
) (
    input  logic [N-1:0]  free_i,
    output logic          any_o,
    output logic [TW-1:0] idx_o
);
    // lowest set bit wins: scan downwards so the last hit is the smallest index
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                idx_o = TW'(i);
            end
        end
    end

    assign any_o = |free_i;
endmodule

// File: rtl/df_regtab.sv
module df_regtab #(
    parameter int NUM_ARCH = 32,
    parameter int NUM_ENT  = 16,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_ENT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_dst,
    input  logic [TW-1:0]       wr_tag,
    input  logic [NUM_ENT-1:0]  done_i,
    input  logic [AW-1:0]       rd_a,
    input  logic [AW-1:0]       rd_b,
    output logic                busy_a,
    output logic [TW-1:0]       tag_a,
    output logic                busy_b,
    output logic [TW-1:0]       tag_b,
    output logic [NUM_ARCH-1:0] pend_o
);
    logic [NUM_ARCH-1:0] busy_q;
    logic [TW-1:0]       tag_q [NUM_ARCH];

    // a new writer overrides; otherwise only a broadcast of the recorded tag clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int r = 0; r < NUM_ARCH; r++) begin
                tag_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NUM_ARCH; r++) begin
                if (wr_en && (wr_dst == AW'(r))) begin
                    busy_q[r] <= 1'b1;
                    tag_q[r]  <= wr_tag;
                end else if (busy_q[r] && done_i[tag_q[r]]) begin
                    busy_q[r] <= 1'b0;
                end
            end
        end
    end

    assign busy_a = busy_q[rd_a];
    assign tag_a  = tag_q[rd_a];
    assign busy_b = busy_q[rd_b];
    assign tag_b  = tag_q[rd_b];
    assign pend_o = busy_q;
endmodule

// File: rtl/df_slot.sv
module df_slot
    import df_sched_pkg::*;
#(
    parameter int NUM_ENT  = 16,
    parameter int LAT_LOAD = 2,
    parameter int LAT_ADD  = 4,
    parameter int LAT_MUL  = 20,
    localparam int TW   = $clog2(NUM_ENT),
    localparam int LMAX = (LAT_MUL > LAT_ADD)
                          ? ((LAT_MUL > LAT_LOAD) ? LAT_MUL : LAT_LOAD)
                          : ((LAT_ADD > LAT_LOAD) ? LAT_ADD : LAT_LOAD),
    localparam int CW   = $clog2(LMAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  op_e                op_i,
    input  logic               wait_a_i,
    input  logic [TW-1:0]      tag_a_i,
    input  logic               wait_b_i,
    input  logic [TW-1:0]      tag_b_i,
    input  logic [NUM_ENT-1:0] wake_i,
    output logic               occ_o,
    output logic               wait_o,
    output logic               done_o
);
    slot_st_e      st_q, st_d;
    op_e           op_q, op_d;
    logic          wa_q, wa_d, wb_q, wb_d;
    logic [TW-1:0] ta_q, ta_d, tb_q, tb_d;
    logic [CW-1:0] rem_q, rem_d;
    logic          ra, rb;

    // remaining count loaded at start: the start cycle itself is the first one
    function automatic logic [CW-1:0] cnt_init(op_e op);
        unique case (op)
            OP_LOAD: cnt_init = CW'(LAT_LOAD - 1);
            OP_MUL:  cnt_init = CW'(LAT_MUL - 1);
            default: cnt_init = CW'(LAT_ADD - 1);
        endcase
    endfunction

    assign ra = !wa_q || wake_i[ta_q];
    assign rb = !wb_q || wake_i[tb_q];

    always_comb begin
        st_d  = st_q;
        op_d  = op_q;
        wa_d  = wa_q;
        wb_d  = wb_q;
        ta_d  = ta_q;
        tb_d  = tb_q;
        rem_d = rem_q;
        unique case (st_q)
            SL_FREE: begin
                if (alloc_i) begin
                    op_d = op_i;
                    wa_d = wait_a_i;
                    wb_d = wait_b_i;
                    ta_d = tag_a_i;
                    tb_d = tag_b_i;
                    if (!wait_a_i && !wait_b_i) begin
                        st_d  = SL_EXEC;
                        rem_d = cnt_init(op_i);
                    end else begin
                        st_d = SL_WAIT;
                    end
                end
            end
            SL_WAIT: begin
                if (ra && rb) begin
                    st_d  = SL_EXEC;
                    rem_d = cnt_init(op_q);
                    wa_d  = 1'b0;
                    wb_d  = 1'b0;
                end else begin
                    wa_d = !ra;
                    wb_d = !rb;
                end
            end
            SL_EXEC: begin
                if (rem_q == '0) begin
                    st_d = SL_FREE;
                end else begin
                    rem_d = rem_q - CW'(1);
                end
            end
            default: st_d = SL_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SL_FREE;
            op_q  <= OP_ADD;
            wa_q  <= 1'b0;
            wb_q  <= 1'b0;
            ta_q  <= '0;
            tb_q  <= '0;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            op_q  <= op_d;
            wa_q  <= wa_d;
            wb_q  <= wb_d;
            ta_q  <= ta_d;
            tb_q  <= tb_d;
            rem_q <= rem_d;
        end
    end

    always_comb begin
        occ_o  = (st_q != SL_FREE);
        wait_o = (st_q == SL_WAIT);
        done_o = (st_q == SL_EXEC) && (rem_q == '0);
    end
endmodule

// File: rtl/df_sched.sv
module df_sched
    import df_sched_pkg::*;
#(
    parameter int NUM_ARCH = 32,
    parameter int NUM_ENT  = 16,
    parameter int LAT_LOAD = 2,
    parameter int LAT_ADD  = 4,
    parameter int LAT_MUL  = 20,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_ENT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          in_op,
    input  logic [AW-1:0]       in_dst,
    input  logic [AW-1:0]       in_src_a,
    input  logic                in_src_a_en,
    input  logic [AW-1:0]       in_src_b,
    input  logic                in_src_b_en,
    output logic                in_ready,
    output logic [TW-1:0]       in_tag,
    output logic [NUM_ENT-1:0]  done_vec,
    output logic [NUM_ARCH-1:0] reg_pending
);
    op_e                op_in;
    logic               issue;
    logic               use_a, use_b;
    logic               busy_a, busy_b;
    logic [TW-1:0]      ptag_a, ptag_b;
    logic               miss_a, miss_b;
    logic [NUM_ENT-1:0] occ_vec;
    logic [NUM_ENT-1:0] wait_vec;

    assign op_in = op_e'(in_op);
    assign issue = in_valid && in_ready;

    // loads carry no register sources whatever the enables say
    assign use_a = in_src_a_en && (op_in != OP_LOAD);
    assign use_b = in_src_b_en && (op_in != OP_LOAD);

    // a producer broadcasting this very cycle counts as ready (same-cycle bypass)
    assign miss_a = use_a && busy_a && !done_vec[ptag_a];
    assign miss_b = use_b && busy_b && !done_vec[ptag_b];

    df_pick #(.N(NUM_ENT)) u_pick (
        .free_i (~occ_vec),
        .any_o  (in_ready),
        .idx_o  (in_tag)
    );

    df_regtab #(.NUM_ARCH(NUM_ARCH), .NUM_ENT(NUM_ENT)) u_regtab (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (issue),
        .wr_dst (in_dst),
        .wr_tag (in_tag),
        .done_i (done_vec),
        .rd_a   (in_src_a),
        .rd_b   (in_src_b),
        .busy_a (busy_a),
        .tag_a  (ptag_a),
        .busy_b (busy_b),
        .tag_b  (ptag_b),
        .pend_o (reg_pending)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        df_slot #(
            .NUM_ENT  (NUM_ENT),
            .LAT_LOAD (LAT_LOAD),
            .LAT_ADD  (LAT_ADD),
            .LAT_MUL  (LAT_MUL)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_i  (issue && (in_tag == TW'(g))),
            .op_i     (op_in),
            .wait_a_i (miss_a),
            .tag_a_i  (ptag_a),
            .wait_b_i (miss_b),
            .tag_b_i  (ptag_b),
            .wake_i   (done_vec),
            .occ_o    (occ_vec[g]),
            .wait_o   (wait_vec[g]),
            .done_o   (done_vec[g])
        );
    end
endmodule

// File: rtl/df_sched_sva.sv
module df_sched_sva #(
    parameter int NUM_ARCH = 32,
    parameter int NUM_ENT  = 16,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(NUM_ENT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [1:0]          in_op,
    input logic [AW-1:0]       in_dst,
    input logic [TW-1:0]       in_tag,
    input logic [NUM_ENT-1:0]  done_vec,
    input logic [NUM_ENT-1:0]  occ_vec,
    input logic [NUM_ENT-1:0]  wait_vec,
    input logic [NUM_ARCH-1:0] reg_pending
);
    AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> occ_vec[$past(in_tag)]); // R1

    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_vec) |=> ((occ_vec & $past(done_vec)) == '0)); // R2

    AST_LOAD_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_op == 2'b00)) |=> !wait_vec[$past(in_tag)]); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_vec) |=> ((done_vec & $past(done_vec)) == '0)); // R6

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> reg_pending[$past(in_dst)]); // R7
endmodule

bind df_sched df_sched_sva #(.NUM_ARCH(NUM_ARCH), .NUM_ENT(NUM_ENT)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_op       (in_op),
    .in_dst      (in_dst),
    .in_tag      (in_tag),
    .done_vec    (done_vec),
    .occ_vec     (occ_vec),
    .wait_vec    (wait_vec),
    .reg_pending (reg_pending)
);

// File: tb/df_sched_bench.sv
module df_sched_bench;
    localparam int NA = 32;
    localparam int NE = 16;
    localparam int AW = 5;
    localparam int TW = 4;
    localparam int L_LD = 2;
    localparam int L_AD = 4;
    localparam int L_MU = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_op = 2'b00;
    logic [AW-1:0] in_dst = '0;
    logic [AW-1:0] in_src_a = '0;
    logic          in_src_a_en = 1'b0;
    logic [AW-1:0] in_src_b = '0;
    logic          in_src_b_en = 1'b0;
    logic          in_ready;
    logic [TW-1:0] in_tag;
    logic [NE-1:0] done_vec;
    logic [NA-1:0] reg_pending;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int t_I [NE];
    int t_R [NE];
    bit t_used [NE];
    int last_I [NA];
    int last_R [NA];
    int watch_cyc = -1;
    int watch_tag = 0;
    int stalls = 0;
    bit last_acc;
    int last_tag;

    df_sched u_df_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
        .in_src_b(in_src_b), .in_src_b_en(in_src_b_en), .in_ready(in_ready),
        .in_tag(in_tag), .done_vec(done_vec), .reg_pending(reg_pending)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", what, cyc, act, exp);
        end
    endtask

    function automatic int lat_of(input int op);
        if (op == 0) return L_LD;
        if (op == 2) return L_MU;
        return L_AD;
    endfunction

    // expectations for the current cycle, from operations issued in earlier cycles
    task automatic check_cycle(output bit exp_rdy, output int exp_tag);
        logic [NE-1:0] e_done = '0;
        logic [NA-1:0] e_pend = '0;
        exp_rdy = 1'b0;
        exp_tag = 0;
        for (int t = NE - 1; t >= 0; t--) begin
            bit occ = t_used[t] && (t_I[t] < cyc) && (cyc <= t_R[t]);
            if (t_used[t] && (t_R[t] == cyc)) e_done[t] = 1'b1;
            if (!occ) begin
                exp_rdy = 1'b1;
                exp_tag = t;
            end
        end
        for (int r = 0; r < NA; r++) begin
            e_pend[r] = (last_I[r] < cyc) && (cyc <= last_R[r]);
        end
        chk(done_vec == e_done, "R3 R4 R5 R6 R8 done_vec", done_vec, e_done);
        chk(reg_pending == e_pend, "R7 R8 R10 reg_pending", reg_pending, e_pend);
        chk(in_ready == exp_rdy, "R2 in_ready", in_ready, exp_rdy);
        if (exp_rdy) chk(in_tag == TW'(exp_tag), "R1 in_tag", in_tag, exp_tag);
        if (cyc == watch_cyc) chk(done_vec[watch_tag] == 1'b1, "R4 chained result cycle", done_vec[watch_tag], 1);
    endtask

    task automatic step(input bit v, input int op, input int d, input int sa, input bit ea,
                        input int sb, input bit eb);
        bit er;
        int et;
        @(posedge clk);
        #1;
        in_valid = v;
        in_op = op[1:0];
        in_dst = AW'(d);
        in_src_a = AW'(sa);
        in_src_a_en = ea;
        in_src_b = AW'(sb);
        in_src_b_en = eb;
        @(negedge clk);
        check_cycle(er, et);
        last_acc = v && er;
        last_tag = et;
        if (v && !er) stalls++;
        if (v && er) begin
            int st = cyc;
            if (op != 0 && ea && last_R[sa] > st) st = last_R[sa];
            if (op != 0 && eb && last_R[sb] > st) st = last_R[sb];
            t_used[et] = 1'b1;
            t_I[et] = cyc;
            t_R[et] = st + lat_of(op);
            last_I[d] = cyc;
            last_R[d] = st + lat_of(op);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int base;
        for (int t = 0; t < NE; t++) begin t_used[t] = 0; t_I[t] = -1; t_R[t] = -1; end
        for (int r = 0; r < NA; r++) begin last_I[r] = -1; last_R[r] = -1; end
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
        chk(in_tag == '0, "R9 in_tag", in_tag, 0);
        chk(done_vec == '0, "R9 done_vec", done_vec, 0);
        chk(reg_pending == '0, "R9 reg_pending", reg_pending, 0);

        // dependent load/load/multiply/accumulate chain, four iterations
        base = cyc + 1;
        for (int k = 0; k < 4; k++) begin
            step(1, 0, 10, 5, 1, 6, 1);
            step(1, 0, 12, 7, 1, 8, 1);
            step(1, 2, 10, 10, 1, 12, 1);
            step(1, 1, 8, 8, 1, 10, 1);
            if (k == 0) begin
                watch_tag = last_tag;
                watch_cyc = base + 27;
            end
        end
        idle(60);

        // R5: load whose enabled source is still pending starts at once
        step(1, 2, 20, 0, 0, 0, 0);
        step(1, 0, 21, 20, 1, 20, 1);
        // R8: rewrite r20 with a short load; reader waits only on the young one
        step(1, 0, 20, 0, 0, 0, 0);
        step(1, 1, 22, 20, 1, 21, 1);
        idle(30);

        // R2: fill every slot with independent multiplies
        stalls = 0;
        for (int i = 0; i < 20; i++) step(1, 2, i, 0, 0, 0, 0);
        chk(stalls > 0, "R2 full stall seen", stalls, 1);
        idle(30);

        // seeded random mix over a small register set
        for (int i = 0; i < 1500; i++) begin
            int op = $urandom_range(0, 2);
            step($urandom_range(0, 9) < 7, op, $urandom_range(0, 7),
                 $urandom_range(0, 7), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 7), $urandom_range(0, 1) == 1);
        end
        idle(40);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual %0d expected done", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule